// File: doc/BRIEF.md
# Next-Instruction-Address Sequencer with Execute Chains

This block decides where a small word-addressed processor fetches next. Each time a fetched word comes back, the decoder hands it the word's class, a 4-bit mask field, the current 4-bit condition code, the effective address and, for branch kinds it does not judge itself, a taken flag. From these the block forms the next fetch address and keeps the instruction address register up to date.

An execute instruction runs the word at its effective address as a subject. A subject may itself be an execute instruction, and such chains may be of any length. None of the links moves the instruction address. When the chain ends, the flow resumes after the first link, unless the subject transfers control.

An interrupt or trap taken inside a chain returns to the first link, so the whole chain runs again. In real extended mode, targets may lie above the low 128K words, but sequential flow wraps back into that low region.

Top module: `nia_sequencer`

## Requirements
- R1: While `rst` is high, on the next clock edge the block sets `fetch_req`, `fetch_addr`, `inst_addr`, `chain_active` and `ret_vld` to zero.
- R2: Only one fetch is outstanding at a time. `fetch_req` stays high and `fetch_addr` stays stable until a cycle with `instr_vld` high accepts the word. `fetch_req` is then low for exactly one cycle and rises again with the new address.
- R3: Class 2 (branch-if-any-set) transfers to `eff_addr` when `r_mask & cc` is nonzero, and falls through otherwise. With a mask of 0 it never transfers.
- R4: Class 3 (branch-if-none-set) transfers to `eff_addr` when `r_mask & cc` is zero, and falls through otherwise. With a mask of 0 it always transfers.
- R5: Class 1 (other branch) transfers to `eff_addr` when `other_taken` is high. Class 5 (status load) always transfers to `eff_addr`. Class 0 and the unused codes 6 and 7 are ordinary and fall through.
- R6: Class 4 (execute) fetches next from `eff_addr` and leaves `inst_addr` unchanged. The first link of a chain sets `chain_active` and records its own address in `chain_origin`. Later links leave `chain_origin` unchanged.
- R7: A non-execute subject ends the chain and clears `chain_active`. Next comes the sequential successor of the first link, unless the subject transfers control, in which case its target comes next.
- R8: An interrupt (`irq_take` with the accepted word) discards the word and pulses `ret_vld` in the cycle after acceptance, with `ret_is_trap`=0. `ret_addr` is `chain_origin` if a chain is active, else the fetched word's address. Fetch continues at `vec_addr`, and the chain is cleared.
- R9: A trap (`trap_hit`) behaves as in R8 but with `ret_is_trap`=1. A trap wins over a simultaneous interrupt.
- R10: The sequential successor is `inst_addr`+1. With `ext_mode` high it is reduced to the low 17 bits. With `ext_mode` low it wraps at 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Real extended addressing mode |
| instr_vld | input | 1 | Fetched word returned and decoded |
| instr_cls | input | 3 | Word class (0 ordinary, 1 other branch, 2 any-set, 3 none-set, 4 execute, 5 status load) |
| r_mask | input | 4 | Mask field of the word |
| cc | input | 4 | Current condition code |
| eff_addr | input | 20 | Effective address of the word |
| other_taken | input | 1 | Taken flag for class 1 |
| irq_take | input | 1 | Interrupt accepted at this word |
| trap_hit | input | 1 | Trap raised by this word |
| vec_addr | input | 20 | Handler address for interrupt or trap |
| fetch_req | output | 1 | Fetch outstanding |
| fetch_addr | output | 20 | Address being fetched |
| inst_addr | output | 20 | Instruction address register |
| chain_active | output | 1 | Execute chain in progress |
| chain_origin | output | 20 | Address of the first link of the chain |
| ret_vld | output | 1 | Return address valid (one cycle) |
| ret_addr | output | 20 | Return address to save |
| ret_is_trap | output | 1 | 1 when ret_addr is due to a trap |

## Verification
Every result of an accepted word is due one clock after acceptance. That is the cycle in which `fetch_req` is low: `fetch_addr`, `inst_addr`, the chain state and the return pulse all update together there. The bench drives a word at a falling edge while `fetch_req` is high and queues the expected results. A monitor then pops and compares them only at the falling edge where `fetch_req` reads low, which is exactly that one-cycle-later point. Idle gaps before acceptance check that the fetch address holds.

// File: rtl/nia_pkg.sv
package nia_pkg;

    localparam int unsigned NIA_AW  = 20;
    localparam int unsigned NIA_LW  = 17;
    localparam int unsigned NIA_FW  = 4;

    typedef enum logic [2:0] {
        CL_SEQ    = 3'd0,
        CL_BR_ANY = 3'd1,
        CL_BR_SET = 3'd2,
        CL_BR_CLR = 3'd3,
        CL_EXEC   = 3'd4,
        CL_STATUS = 3'd5
    } icls_e;

    typedef struct packed {
        logic xfer;
        logic exec;
    } dec_t;

    function automatic logic any_hit(input logic [NIA_FW-1:0] m, input logic [NIA_FW-1:0] c);
        return |(m & c);
    endfunction

endpackage

// File: rtl/nia_cond.sv
module nia_cond
    import nia_pkg::*;
(
    input  logic [2:0]        cls,
    input  logic [NIA_FW-1:0] mask,
    input  logic [NIA_FW-1:0] cc,
    input  logic              other_taken,
    output dec_t              dec
);
    icls_e k;
    logic  hit;

    assign k   = icls_e'(cls);
    assign hit = any_hit(mask, cc);

    always_comb begin
        dec = '0;
        case (k)
            CL_BR_SET: dec.xfer = hit;
            CL_BR_CLR: dec.xfer = ~hit;
            CL_BR_ANY: dec.xfer = other_taken;
            CL_STATUS: dec.xfer = 1'b1;
            CL_EXEC:   dec.exec = 1'b1;
            default:   dec      = '0;
        endcase
    end
endmodule

// File: rtl/nia_chain.sv
module nia_chain #(
    parameter int unsigned AW = nia_pkg::NIA_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          evt,
    input  logic          is_exec,
    input  logic [AW-1:0] cur_addr,
    output logic          chain_on,
    output logic [AW-1:0] chain_org
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_on  <= 1'b0;
            chain_org <= '0;
        end else if (accept) begin
            if (evt) begin
                chain_on <= 1'b0;
            end else if (is_exec) begin
                if (!chain_on) begin
                    chain_on  <= 1'b1;
                    chain_org <= cur_addr;
                end
            end else begin
                chain_on <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nia_addr.sv
module nia_addr #(
    parameter int unsigned AW = nia_pkg::NIA_AW,
    parameter int unsigned LW = nia_pkg::NIA_LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_vld,
    input  logic          ext_mode,
    input  logic          evt,
    input  nia_pkg::dec_t dec,
    input  logic [AW-1:0] tgt,
    input  logic [AW-1:0] vec,
    output logic          accept,
    output logic          fetch_req,
    output logic [AW-1:0] fa,
    output logic [AW-1:0] ia
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] inc_full;
    logic [AW-1:0] inc_low;
    logic [AW-1:0] seq_nxt;
    logic [AW-1:0] nxt;

    assign accept   = fetch_req & instr_vld;
    assign inc_full = ia + ONE;

    generate
        if (LW < AW) begin : g_fold
            assign inc_low = {{(AW-LW){1'b0}}, inc_full[LW-1:0]};
        end else begin : g_flat
            assign inc_low = inc_full;
        end
    endgenerate

    assign seq_nxt = ext_mode ? inc_low : inc_full;
    assign nxt     = dec.xfer ? tgt : seq_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_req <= 1'b0;
            fa        <= '0;
            ia        <= '0;
        end else if (!fetch_req) begin
            fetch_req <= 1'b1;
        end else if (instr_vld) begin
            fetch_req <= 1'b0;
            if (evt) begin
                fa <= vec;
                ia <= vec;
            end else if (dec.exec) begin
                fa <= tgt;
            end else begin
                fa <= nxt;
                ia <= nxt;
            end
        end
    end
endmodule

// File: rtl/nia_ret.sv
module nia_ret #(
    parameter int unsigned AW = nia_pkg::NIA_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          irq,
    input  logic          trap,
    input  logic          chain_on,
    input  logic [AW-1:0] chain_org,
    input  logic [AW-1:0] cur_addr,
    output logic          ret_vld,
    output logic [AW-1:0] ret_addr,
    output logic          ret_is_trap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ret_vld     <= 1'b0;
            ret_addr    <= '0;
            ret_is_trap <= 1'b0;
        end else begin
            ret_vld <= accept & (irq | trap);
            if (accept & (irq | trap)) begin
                ret_addr    <= chain_on ? chain_org : cur_addr;
                ret_is_trap <= trap;
            end
        end
    end
endmodule

// File: rtl/nia_sequencer.sv
module nia_sequencer
    import nia_pkg::*;
#(
    parameter int unsigned AW = NIA_AW,
    parameter int unsigned LW = NIA_LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_mode,
    input  logic          instr_vld,
    input  logic [2:0]    instr_cls,
    input  logic [3:0]    r_mask,
    input  logic [3:0]    cc,
    input  logic [AW-1:0] eff_addr,
    input  logic          other_taken,
    input  logic          irq_take,
    input  logic          trap_hit,
    input  logic [AW-1:0] vec_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] inst_addr,
    output logic          chain_active,
    output logic [AW-1:0] chain_origin,
    output logic          ret_vld,
    output logic [AW-1:0] ret_addr,
    output logic          ret_is_trap
);
    dec_t dec;
    logic accept;
    logic evt;

    assign evt = irq_take | trap_hit;

    nia_cond u_cond (
        .cls         (instr_cls),
        .mask        (r_mask),
        .cc          (cc),
        .other_taken (other_taken),
        .dec         (dec)
    );

    nia_addr #(.AW(AW), .LW(LW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .instr_vld (instr_vld),
        .ext_mode  (ext_mode),
        .evt       (evt),
        .dec       (dec),
        .tgt       (eff_addr),
        .vec       (vec_addr),
        .accept    (accept),
        .fetch_req (fetch_req),
        .fa        (fetch_addr),
        .ia        (inst_addr)
    );

    nia_chain #(.AW(AW)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .evt       (evt),
        .is_exec   (dec.exec),
        .cur_addr  (fetch_addr),
        .chain_on  (chain_active),
        .chain_org (chain_origin)
    );

    nia_ret #(.AW(AW)) u_ret (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .irq         (irq_take),
        .trap        (trap_hit),
        .chain_on    (chain_active),
        .chain_org   (chain_origin),
        .cur_addr    (fetch_addr),
        .ret_vld     (ret_vld),
        .ret_addr    (ret_addr),
        .ret_is_trap (ret_is_trap)
    );
endmodule

// File: rtl/nia_sequencer_chk.sv
module nia_sequencer_chk #(
    parameter int unsigned AW = 20,
    parameter int unsigned LW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_mode,
    input logic          instr_vld,
    input logic [2:0]    instr_cls,
    input logic [3:0]    r_mask,
    input logic          irq_take,
    input logic          trap_hit,
    input logic [AW-1:0] eff_addr,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic [AW-1:0] inst_addr,
    input logic          chain_active,
    input logic [AW-1:0] chain_origin,
    input logic          ret_vld,
    input logic          ret_is_trap
);
    logic acc;
    logic plain;
    assign acc   = fetch_req & instr_vld;
    assign plain = acc & ~irq_take & ~trap_hit;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!fetch_req && fetch_addr == '0 && inst_addr == '0 && !chain_active && !ret_vld));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !instr_vld) |=> (fetch_req && $stable(fetch_addr)));

    p_gap_r2: assert property (@(posedge clk) disable iff (rst)
        acc |=> !fetch_req);

    p_refetch_r2: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |=> fetch_req);

    p_set_noop_r3: assert property (@(posedge clk) disable iff (rst)
        (plain && instr_cls == 3'd2 && r_mask == 4'd0 && !chain_active && !ext_mode)
        |=> fetch_addr == $past(fetch_addr) + 1'b1);

    p_clr_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (plain && instr_cls == 3'd3 && r_mask == 4'd0) |=> fetch_addr == $past(eff_addr));

    p_exec_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (plain && instr_cls == 3'd4)
        |=> ($stable(inst_addr) && chain_active && fetch_addr == $past(eff_addr)));

    p_origin_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (plain && instr_cls == 3'd4 && chain_active) |=> $stable(chain_origin));

    p_chain_end_r7: assert property (@(posedge clk) disable iff (rst)
        (plain && instr_cls != 3'd4) |=> !chain_active);

    p_ret_cause_r8: assert property (@(posedge clk) disable iff (rst)
        ret_vld |-> $past(acc && (irq_take || trap_hit)));

    p_trap_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_vld && ret_is_trap) |-> $past(trap_hit));

    p_ext_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (plain && instr_cls == 3'd0 && ext_mode) |=> fetch_addr[AW-1:LW] == '0);
endmodule

bind nia_sequencer nia_sequencer_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_mode     (ext_mode),
    .instr_vld    (instr_vld),
    .instr_cls    (instr_cls),
    .r_mask       (r_mask),
    .irq_take     (irq_take),
    .trap_hit     (trap_hit),
    .eff_addr     (eff_addr),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .inst_addr    (inst_addr),
    .chain_active (chain_active),
    .chain_origin (chain_origin),
    .ret_vld      (ret_vld),
    .ret_is_trap  (ret_is_trap)
);

// File: tb/nia_sequencer_bench.sv
module nia_sequencer_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_mode = 1'b0;
    logic          instr_vld = 1'b0;
    logic [2:0]    instr_cls = '0;
    logic [3:0]    r_mask = '0;
    logic [3:0]    cc = '0;
    logic [AW-1:0] eff_addr = '0;
    logic          other_taken = 1'b0;
    logic          irq_take = 1'b0;
    logic          trap_hit = 1'b0;
    logic [AW-1:0] vec_addr = '0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic [AW-1:0] inst_addr;
    logic          chain_active;
    logic [AW-1:0] chain_origin;
    logic          ret_vld;
    logic [AW-1:0] ret_addr;
    logic          ret_is_trap;

    always #4 clk = ~clk;

    nia_sequencer u_nia_sequencer (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .instr_vld(instr_vld),
        .instr_cls(instr_cls), .r_mask(r_mask), .cc(cc), .eff_addr(eff_addr),
        .other_taken(other_taken), .irq_take(irq_take), .trap_hit(trap_hit),
        .vec_addr(vec_addr), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .inst_addr(inst_addr), .chain_active(chain_active), .chain_origin(chain_origin),
        .ret_vld(ret_vld), .ret_addr(ret_addr), .ret_is_trap(ret_is_trap)
    );

    typedef struct {
        string         tag;
        logic [AW-1:0] fa;
        logic [AW-1:0] ia;
        logic          ch;
        logic [AW-1:0] org;
        logic          rv;
        logic [AW-1:0] ra;
        logic          rt;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [AW-1:0] m_fa = '0, m_ia = '0, m_org = '0;
    logic          m_ch = 1'b0;

    function automatic logic [AW-1:0] succ(input logic [AW-1:0] a, input logic ext);
        logic [AW-1:0] s;
        s = a + 20'd1;
        return ext ? {3'b000, s[16:0]} : s;
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cycles);
            report();
            $finish;
        end
    end

    // monitor: results are due in the cycle where fetch_req reads low after acceptance
    always @(negedge clk) begin
        if (!rst && !fetch_req && q.size() > 0) begin
            exp_t e;
            logic ok;
            e  = q.pop_front();
            ok = (fetch_addr == e.fa) && (inst_addr == e.ia) && (chain_active == e.ch)
                 && (!e.ch || chain_origin == e.org) && (ret_vld == e.rv)
                 && (!e.rv || (ret_addr == e.ra && ret_is_trap == e.rt));
            n_chk = n_chk + 1;
            if (!ok) begin
                n_bad = n_bad + 1;
                $display("FAIL %s: actual fa=%h ia=%h ch=%b org=%h rv=%b ra=%h rt=%b expected fa=%h ia=%h ch=%b org=%h rv=%b ra=%h rt=%b",
                         e.tag, fetch_addr, inst_addr, chain_active, chain_origin, ret_vld, ret_addr,
                         ret_is_trap, e.fa, e.ia, e.ch, e.org, e.rv, e.ra, e.rt);
            end
        end
    end

    task automatic step(input logic [2:0] c, input logic [3:0] m, input logic [3:0] k,
                        input logic [AW-1:0] ea, input logic ot, input logic irq,
                        input logic trp, input logic ext, input logic [AW-1:0] vec,
                        input int gap);
        exp_t e;
        logic [AW-1:0] held;
        logic tk;
        @(negedge clk);
        while (!fetch_req) @(negedge clk);
        if (gap > 0) begin
            held = fetch_addr;
            repeat (gap) @(negedge clk);
            n_chk = n_chk + 1;
            if (!fetch_req || fetch_addr != held) begin
                n_bad = n_bad + 1;
                $display("FAIL R2: actual req=%b fa=%h expected req=1 fa=%h", fetch_req, fetch_addr, held);
            end
        end
        instr_cls = c; r_mask = m; cc = k; eff_addr = ea; other_taken = ot;
        irq_take = irq; trap_hit = trp; ext_mode = ext; vec_addr = vec; instr_vld = 1'b1;
        e.rv = 1'b0; e.ra = '0; e.rt = 1'b0;
        if (irq || trp) begin
            e.tag = trp ? "R9" : "R8";
            e.rv = 1'b1; e.rt = trp; e.ra = m_ch ? m_org : m_fa;
            m_fa = vec; m_ia = vec; m_ch = 1'b0;
        end else if (c == 3'd4) begin
            e.tag = "R6";
            if (!m_ch) begin m_org = m_fa; m_ch = 1'b1; end
            m_fa = ea;
        end else begin
            case (c)
                3'd1: begin tk = ot; e.tag = "R5"; end
                3'd2: begin tk = (m & k) != 4'd0; e.tag = "R3"; end
                3'd3: begin tk = (m & k) == 4'd0; e.tag = "R4"; end
                3'd5: begin tk = 1'b1; e.tag = "R5"; end
                default: begin tk = 1'b0; e.tag = "R10"; end
            endcase
            if (m_ch) e.tag = {e.tag, "/R7"};
            m_fa = tk ? ea : succ(m_ia, ext);
            m_ia = m_fa; m_ch = 1'b0;
        end
        e.fa = m_fa; e.ia = m_ia; e.ch = m_ch; e.org = m_org;
        q.push_back(e);
        @(negedge clk);
        instr_vld = 1'b0; irq_take = 1'b0; trap_hit = 1'b0;
    endtask

    task automatic check_reset();
        n_chk = n_chk + 1;
        if (fetch_req || fetch_addr != '0 || inst_addr != '0 || chain_active || ret_vld) begin
            n_bad = n_bad + 1;
            $display("FAIL R1: actual req=%b fa=%h ia=%h ch=%b rv=%b expected all zero",
                     fetch_req, fetch_addr, inst_addr, chain_active, ret_vld);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        // ordinary and the two mask tests, including mask 0 cases (R3, R4)
        step(3'd0, 4'h0, 4'h0, 20'h00000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd2, 4'h0, 4'hF, 20'h00100, 0, 0, 0, 0, 20'h0, 2);
        step(3'd2, 4'h4, 4'h4, 20'h00200, 0, 0, 0, 0, 20'h0, 0);
        step(3'd2, 4'h8, 4'h7, 20'h00300, 0, 0, 0, 0, 20'h0, 0);
        step(3'd3, 4'h0, 4'hF, 20'h00400, 0, 0, 0, 0, 20'h0, 0);
        step(3'd3, 4'h3, 4'h1, 20'h00500, 0, 0, 0, 0, 20'h0, 0);
        step(3'd3, 4'h3, 4'hC, 20'h00600, 0, 0, 0, 0, 20'h0, 1);
        step(3'd1, 4'h0, 4'h0, 20'h00700, 1, 0, 0, 0, 20'h0, 0);
        step(3'd1, 4'h0, 4'h0, 20'h00800, 0, 0, 0, 0, 20'h0, 0);
        step(3'd5, 4'h0, 4'h0, 20'h01000, 0, 0, 0, 0, 20'h0, 0);
        // chain of three, ends in ordinary word (R6, R7)
        step(3'd4, 4'h0, 4'h0, 20'h02000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd4, 4'h0, 4'h0, 20'h03000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd4, 4'h0, 4'h0, 20'h04000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd0, 4'h0, 4'h0, 20'h05000, 0, 0, 0, 0, 20'h0, 0);
        // chain whose subject branches
        step(3'd4, 4'h0, 4'h0, 20'h06000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd2, 4'h2, 4'h2, 20'h07000, 0, 0, 0, 0, 20'h0, 0);
        // interrupt inside a chain (R8), trap inside a chain (R9), both at once
        step(3'd4, 4'h0, 4'h0, 20'h08000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd4, 4'h0, 4'h0, 20'h09000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd0, 4'h0, 4'h0, 20'h00000, 0, 1, 0, 0, 20'h00040, 0);
        step(3'd4, 4'h0, 4'h0, 20'h0A000, 0, 0, 0, 0, 20'h0, 0);
        step(3'd4, 4'h0, 4'h0, 20'h0B000, 0, 0, 1, 0, 20'h00050, 0);
        step(3'd0, 4'h0, 4'h0, 20'h00000, 0, 1, 1, 0, 20'h00060, 0);
        // extended mode wrap (R10)
        step(3'd1, 4'h0, 4'h0, 20'h3FFFF, 1, 0, 0, 1, 20'h0, 0);
        step(3'd0, 4'h0, 4'h0, 20'h00000, 0, 0, 0, 1, 20'h0, 0);
        step(3'd1, 4'h0, 4'h0, 20'h2ABCD, 1, 0, 0, 1, 20'h0, 0);
        step(3'd0, 4'h0, 4'h0, 20'h00000, 0, 0, 0, 1, 20'h0, 0);
        step(3'd1, 4'h0, 4'h0, 20'hFFFFF, 1, 0, 0, 0, 20'h0, 0);
        step(3'd0, 4'h0, 4'h0, 20'h00000, 0, 0, 0, 0, 20'h0, 0);
        // random sequences
        for (int i = 0; i < 800; i++) begin
            int r;
            logic [2:0] c;
            r = $urandom_range(0, 99);
            c = (r < 35) ? 3'd4 : 3'($urandom_range(0, 7));
            step(c, 4'($urandom), 4'($urandom), 20'($urandom), 1'($urandom),
                 ($urandom_range(0, 15) == 0), ($urandom_range(0, 19) == 0),
                 ($urandom_range(0, 3) == 0), 20'($urandom), $urandom_range(0, 2));
        end
        // reset after activity (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset();
        q.delete();
        report();
        $finish;
    end
endmodule